// File: doc/BRIEF.md
# Microcontroller low-power mode sequencer

This block sequences the two sleep depths of a small microcontroller core. Software starts either one by writing a single register on a simple register bus. In halt, the deep state, the oscillator and every subsystem enable are switched off. In idle, the lighter state, the oscillator, the watchdog clock and the interval-timer clock keep running, and the timer wakes the core. The block drives one enable per clock domain and a stall line that holds the core while it sleeps.

Halt ends only when the wake-up edge-detection logic reports a multi-input wake event. The oscillator is then restarted, and the core stays stalled for a fixed settle period counted in oscillator cycles. Idle ends when the interval timer wraps and sets its pending flag. When that happens, a timer interrupt request goes out if the timer interrupt is enabled and the core's global interrupt enable is set. After either wake-up, software writes zero to a clear register, and only then is normal mode re-armed.

There is no streaming data path. Every pin is a plain control or status signal. A bus write takes effect on the clock edge that samples `bus_wr`, and reads are combinational from `bus_addr`.

Top module: `pwr_mode_seq`

## Requirements
- R1: A write to the mode register (address 0) in normal mode enters halt when data bit 0 is 1, or enters idle when bit 0 is 0 and bit 1 is 1. The new mode is visible on the outputs after the sampling edge. If both bits are 1, halt wins.
- R2: Reads return zero at address 0 (the mode register) and at address 1 (the clear register). The timer control register at address 2 reads with the interrupt enable in bit 0 and the pending flag in bit 1, and zeros above.
- R3: In halt, `osc_en`, `wdt_clk_en`, `tmr_clk_en`, `periph_clk_en`, `lbd_en` and `bor_en` are all 0, and `cpu_stall` is 1.
- R4: Only `wake_evt` ends halt. When `wake_evt` arrives in normal mode, it has no effect.
- R5: After the wake edge, `cpu_stall` stays 1 for exactly SETTLE_CYCLES cycles, with only `osc_en` active. After that, `cpu_stall` is 0 and all enables are 1.
- R6: In idle, `osc_en`, `wdt_clk_en` and `tmr_clk_en` are 1, `periph_clk_en`, `lbd_en` and `bor_en` are 0, and `cpu_stall` is 1.
- R7: The interval timer counts every cycle in which its clock is enabled, and sets the pending flag every TMR_PERIOD counts. Entering idle restarts the count, so idle lasts exactly TMR_PERIOD cycles.
- R8: `tmr_irq` is 1 exactly when the pending flag, the timer interrupt enable and `glb_irq_en` are all 1.
- R9: After a wake-up, writes to the mode register are ignored. A write of zero to the clear register (address 1) returns the block to normal mode.
- R10: A write to address 2 loads the interrupt enable from bit 0. The same write clears the pending flag when bit 1 is 0 and leaves it unchanged when bit 1 is 1. If the timer wraps in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the restarted oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| wake_evt | input | 1 | Multi-input wake-up event |
| glb_irq_en | input | 1 | Global interrupt enable of the core |
| osc_en | output | 1 | Oscillator enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| tmr_clk_en | output | 1 | Interval timer clock enable |
| periph_clk_en | output | 1 | Enable for other peripheral clocks |
| lbd_en | output | 1 | Low-battery detector enable |
| bor_en | output | 1 | Brown-out detector enable |
| cpu_stall | output | 1 | Holds the core while it sleeps |
| tmr_irq | output | 1 | Timer interrupt request |

## Verification
Mode entry, wake handling and clear writes change the registered state on the edge that samples the stimulus. The enables and `cpu_stall` therefore move one edge after the input is driven. The settle phase and the idle phase end exactly SETTLE_CYCLES and TMR_PERIOD edges after their starting edge. `bus_rdata` and `tmr_irq` follow their inputs in the same cycle. The bench drives inputs 3 ns after a rising edge. A behavioural model advances on each rising edge, and every output is compared on the falling edge. Directed loops also count the stalled cycles of both sleep phases.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_HALT   = 3'd1,
    PM_SETTLE = 3'd2,
    PM_IDLE   = 3'd3,
    PM_RESUME = 3'd4
  } pm_state_e;

  // Clock domain indices in the enable vector
  localparam int DOM_N      = 6;
  localparam int DOM_OSC    = 0;
  localparam int DOM_WDT    = 1;
  localparam int DOM_TMR    = 2;
  localparam int DOM_PERIPH = 3;
  localparam int DOM_LBD    = 4;
  localparam int DOM_BOR    = 5;

  localparam logic [DOM_N-1:0] KEEP_RUN    = '1;
  localparam logic [DOM_N-1:0] KEEP_HALT   = '0;
  localparam logic [DOM_N-1:0] KEEP_SETTLE = DOM_N'(1) << DOM_OSC;
  localparam logic [DOM_N-1:0] KEEP_IDLE   = (DOM_N'(1) << DOM_OSC) |
                                             (DOM_N'(1) << DOM_WDT) |
                                             (DOM_N'(1) << DOM_TMR);

  // Register addresses and bit positions
  localparam int ADR_MODE      = 0;
  localparam int ADR_CLR       = 1;
  localparam int ADR_TCTL      = 2;
  localparam int MODE_HALT_BIT = 0;
  localparam int MODE_IDLE_BIT = 1;
  localparam int TCTL_IE_BIT   = 0;
  localparam int TCTL_PEND_BIT = 1;
endpackage

// File: rtl/pms_mode_ctrl.sv
module pms_mode_ctrl
  import pms_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_wr,
  input  logic      want_halt,
  input  logic      want_idle,
  input  logic      clr_wr,
  input  logic      wake_evt,
  input  logic      settle_done,
  input  logic      tmr_wrap,
  output pm_state_e state,
  output logic      idle_start
);
  pm_state_e nxt;

  // Idle entry restarts the interval count in the same edge
  assign idle_start = (state == PM_RUN) && mode_wr && !want_halt && want_idle;

  always_comb begin
    nxt = state;
    unique case (state)
      PM_RUN: begin
        if (mode_wr) begin
          if (want_halt)      nxt = PM_HALT;
          else if (want_idle) nxt = PM_IDLE;
        end
      end
      PM_HALT:   if (wake_evt)    nxt = PM_SETTLE;
      PM_SETTLE: if (settle_done) nxt = PM_RESUME;
      PM_IDLE:   if (tmr_wrap)    nxt = PM_RESUME;
      PM_RESUME: if (clr_wr)      nxt = PM_RUN;
      default:                    nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PM_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/pms_settle_cnt.sv
module pms_settle_cnt #(
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign done = active && (cnt == LAST);
endmodule

// File: rtl/pms_interval_tmr.sv
module pms_interval_tmr #(
  parameter int TMR_PERIOD = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic ctrl_wr,
  input  logic ctrl_ie,
  input  logic ctrl_keep_pend,
  output logic wrap,
  output logic pending,
  output logic irq_en
);
  localparam int CW = (TMR_PERIOD > 1) ? $clog2(TMR_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMR_PERIOD - 1);

  logic [CW-1:0] cnt;

  assign wrap = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (wrap)    cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end

  // A wrap in the same cycle as a software clear leaves the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pending <= 1'b0;
    else if (wrap)                       pending <= 1'b1;
    else if (ctrl_wr && !ctrl_keep_pend) pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_en <= 1'b0;
    else if (ctrl_wr) irq_en <= ctrl_ie;
  end
endmodule

// File: rtl/pms_gate_dec.sv
module pms_gate_dec
  import pms_pkg::*;
(
  input  pm_state_e        state,
  output logic [DOM_N-1:0] dom_en,
  output logic             stall
);
  logic [DOM_N-1:0] keep;

  always_comb begin
    unique case (state)
      PM_HALT:   keep = KEEP_HALT;
      PM_SETTLE: keep = KEEP_SETTLE;
      PM_IDLE:   keep = KEEP_IDLE;
      default:   keep = KEEP_RUN;
    endcase
  end

  for (genvar d = 0; d < DOM_N; d++) begin : g_dom
    assign dom_en[d] = keep[d];
  end

  assign stall = (state == PM_HALT) || (state == PM_SETTLE) || (state == PM_IDLE);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1000,
  parameter int TMR_PERIOD    = 8192,
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wake_evt,
  input  logic              glb_irq_en,
  output logic              osc_en,
  output logic              wdt_clk_en,
  output logic              tmr_clk_en,
  output logic              periph_clk_en,
  output logic              lbd_en,
  output logic              bor_en,
  output logic              cpu_stall,
  output logic              tmr_irq
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ADR_CLR);
  localparam logic [ADDR_W-1:0] A_TCTL = ADDR_W'(ADR_TCTL);

  pm_state_e        state;
  logic [DOM_N-1:0] dom_en;
  logic             mode_wr, clr_wr, tctl_wr;
  logic             idle_start, settle_done, tmr_wrap;
  logic             pending, irq_en, tmr_run;

  assign mode_wr = bus_wr && (bus_addr == A_MODE);
  assign clr_wr  = bus_wr && (bus_addr == A_CLR) && (bus_wdata == '0);
  assign tctl_wr = bus_wr && (bus_addr == A_TCTL);

  pms_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .want_halt  (bus_wdata[MODE_HALT_BIT]),
    .want_idle  (bus_wdata[MODE_IDLE_BIT]),
    .clr_wr     (clr_wr),
    .wake_evt   (wake_evt),
    .settle_done(settle_done),
    .tmr_wrap   (tmr_wrap),
    .state      (state),
    .idle_start (idle_start)
  );

  pms_settle_cnt #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .active(state == PM_SETTLE),
    .done  (settle_done)
  );

  pms_gate_dec u_gate (
    .state (state),
    .dom_en(dom_en),
    .stall (cpu_stall)
  );

  assign tmr_run = dom_en[DOM_TMR];

  pms_interval_tmr #(.TMR_PERIOD(TMR_PERIOD)) u_tmr (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (tmr_run),
    .restart       (idle_start),
    .ctrl_wr       (tctl_wr),
    .ctrl_ie       (bus_wdata[TCTL_IE_BIT]),
    .ctrl_keep_pend(bus_wdata[TCTL_PEND_BIT]),
    .wrap          (tmr_wrap),
    .pending       (pending),
    .irq_en        (irq_en)
  );

  // Mode and clear registers are write-only and read as zero
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_TCTL) begin
      bus_rdata[TCTL_IE_BIT]   = irq_en;
      bus_rdata[TCTL_PEND_BIT] = pending;
    end
  end

  assign tmr_irq       = pending && irq_en && glb_irq_en;
  assign osc_en        = dom_en[DOM_OSC];
  assign wdt_clk_en    = dom_en[DOM_WDT];
  assign tmr_clk_en    = dom_en[DOM_TMR];
  assign periph_clk_en = dom_en[DOM_PERIPH];
  assign lbd_en        = dom_en[DOM_LBD];
  assign bor_en        = dom_en[DOM_BOR];
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
  parameter int SETTLE_CYCLES = 1000,
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wake_evt,
  input logic              glb_irq_en,
  input logic              osc_en,
  input logic              wdt_clk_en,
  input logic              tmr_clk_en,
  input logic              periph_clk_en,
  input logic              lbd_en,
  input logic              bor_en,
  input logic              cpu_stall,
  input logic              tmr_irq
);
  logic settle_now;
  int   run_len;

  assign settle_now = osc_en && cpu_stall && !tmr_clk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= 0;
    else if (settle_now) run_len <= run_len + 1;
    else                 run_len <= 0;
  end

  AST_HALT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (cpu_stall && !wdt_clk_en && !tmr_clk_en && !periph_clk_en && !lbd_en && !bor_en)); // R3
  AST_HALT_WAKE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !wake_evt) |=> !osc_en); // R4
  AST_NORMAL_WAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stall && wake_evt && !bus_wr) |=> !cpu_stall); // R4
  AST_WAKE_STARTS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && wake_evt) |=> (osc_en && cpu_stall && !tmr_clk_en)); // R5
  AST_SETTLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!settle_now && run_len != 0) |-> (run_len == SETTLE_CYCLES)); // R5
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clk_en && cpu_stall) |-> (osc_en && wdt_clk_en && !periph_clk_en && !lbd_en && !bor_en)); // R6
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> glb_irq_en); // R8
  AST_MODE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata == '0)); // R2
endmodule

bind pwr_mode_seq pms_checker #(
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W)
) u_pms_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .wake_evt     (wake_evt),
  .glb_irq_en   (glb_irq_en),
  .osc_en       (osc_en),
  .wdt_clk_en   (wdt_clk_en),
  .tmr_clk_en   (tmr_clk_en),
  .periph_clk_en(periph_clk_en),
  .lbd_en       (lbd_en),
  .bor_en       (bor_en),
  .cpu_stall    (cpu_stall),
  .tmr_irq      (tmr_irq)
);

// File: tb/test_pwr_mode_seq.sv
`timescale 1ns/1ps
module test_pwr_mode_seq;
  localparam int SET = 20;
  localparam int PER = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd3;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       wake_evt = 1'b0;
  logic       glb_irq_en = 1'b0;
  logic       osc_en, wdt_clk_en, tmr_clk_en, periph_clk_en, lbd_en, bor_en;
  logic       cpu_stall, tmr_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // Reference model state: 0 normal, 1 halt, 2 settle, 3 idle, 4 resumed
  int ms = 0, mscnt = 0, mtcnt = 0, ns = 0;
  bit mpend = 0, mie = 0, mrun, mwrap, midle_go;

  always #5 clk = ~clk;

  pwr_mode_seq #(.SETTLE_CYCLES(SET), .TMR_PERIOD(PER)) i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_evt(wake_evt),
    .glb_irq_en(glb_irq_en), .osc_en(osc_en), .wdt_clk_en(wdt_clk_en),
    .tmr_clk_en(tmr_clk_en), .periph_clk_en(periph_clk_en), .lbd_en(lbd_en),
    .bor_en(bor_en), .cpu_stall(cpu_stall), .tmr_irq(tmr_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ms = 0; mscnt = 0; mtcnt = 0; mpend = 0; mie = 0;
    end else begin
      mrun = (ms == 0) || (ms == 3) || (ms == 4);
      mwrap = mrun && (mtcnt == PER - 1);
      midle_go = (ms == 0) && bus_wr && (bus_addr == 0) && !bus_wdata[0] && bus_wdata[1];
      if (bus_wr && bus_addr == 2) begin
        mie = bus_wdata[0];
        if (!bus_wdata[1]) mpend = 0;
      end
      if (mwrap) mpend = 1;
      ns = ms;
      case (ms)
        0: if (bus_wr && bus_addr == 0) begin
             if (bus_wdata[0]) ns = 1;
             else if (bus_wdata[1]) ns = 3;
           end
        1: if (wake_evt) ns = 2;
        2: if (mscnt == SET - 1) ns = 4;
        3: if (mwrap) ns = 4;
        4: if (bus_wr && bus_addr == 1 && bus_wdata == 0) ns = 0;
        default: ns = 0;
      endcase
      mscnt = (ms == 2) ? mscnt + 1 : 0;
      if (midle_go) mtcnt = 0;
      else if (mrun) mtcnt = mwrap ? 0 : mtcnt + 1;
      ms = ns;
    end
  end

  function automatic int exp_en(input int s);
    case (s)
      1: return 'h00;
      2: return 'h01;
      3: return 'h07;
      default: return 'h3F;
    endcase
  endfunction

  // Per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int act_en, e_en, e_rd;
      bit e_stall, e_irq;
      act_en = {26'd0, bor_en, lbd_en, periph_clk_en, tmr_clk_en, wdt_clk_en, osc_en};
      e_en = exp_en(ms);
      e_stall = (ms == 1) || (ms == 2) || (ms == 3);
      e_irq = mpend && mie && glb_irq_en;
      e_rd = (bus_addr == 2) ? {30'd0, mpend, mie} : 0;
      case (ms)
        1: chk(act_en == e_en, "R3 halt enables", act_en, e_en);
        2: chk(act_en == e_en, "R5 settle enables", act_en, e_en);
        3: chk(act_en == e_en, "R6 idle enables", act_en, e_en);
        default: chk(act_en == e_en, "R9 run enables", act_en, e_en);
      endcase
      chk(cpu_stall == e_stall, "R4 cpu_stall", cpu_stall, e_stall);
      chk(tmr_irq == e_irq, "R8 tmr_irq", tmr_irq, e_irq);
      chk(int'(bus_rdata) == e_rd, "R2 bus_rdata", bus_rdata, e_rd);
    end
  end

  task automatic nxt(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    nxt(1);
    bus_wr = 1'b0; bus_addr = 2'd3; bus_wdata = 8'd0;
  endtask

  task automatic wake;
    wake_evt = 1'b1;
    nxt(1);
    wake_evt = 1'b0;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (cpu_stall && n < 10000) begin
      nxt(1);
      n++;
    end
  endtask

  initial begin
    int n;
    nxt(3);
    rst_n = 1'b1;
    nxt(1);
    chk({bor_en, lbd_en, periph_clk_en, tmr_clk_en, wdt_clk_en, osc_en} == 6'h3F && !cpu_stall,
        "R1 reset state", cpu_stall, 0);

    // R2: read every address
    bus_addr = 2'd0; #1 chk(bus_rdata == 0, "R2 mode reads 0", bus_rdata, 0);
    bus_addr = 2'd1; #1 chk(bus_rdata == 0, "R2 clear reads 0", bus_rdata, 0);
    bus_addr = 2'd3;

    // R4: wake in normal mode is ignored
    wake();
    nxt(2);
    chk(!cpu_stall && osc_en, "R4 wake ignored in normal", cpu_stall, 0);

    // R1/R3/R4/R5/R9: halt, stay asleep without wake, then wake
    wr(2'd0, 8'h01);
    chk(!osc_en && cpu_stall, "R1 halt entered", osc_en, 0);
    nxt(30);
    chk(!osc_en, "R4 halt held without wake", osc_en, 0);
    wake();
    count_stall(n);
    chk(n == SET, "R5 settle length", n, SET);
    wr(2'd0, 8'h02);
    chk(!cpu_stall, "R9 mode write ignored after wake", cpu_stall, 0);
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h02);
    chk(!cpu_stall, "R9 non-zero clear ignored", cpu_stall, 0);
    wr(2'd1, 8'h00);
    // R1: both bits set picks halt
    wr(2'd0, 8'h03);
    chk(!osc_en && !tmr_clk_en, "R1 halt priority", tmr_clk_en, 0);
    nxt(5);
    wake();
    count_stall(n);
    wr(2'd1, 8'h00);

    // R7/R8: idle with interrupt enabled
    glb_irq_en = 1'b1;
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h02);
    chk(cpu_stall && tmr_clk_en, "R6 idle entered", cpu_stall, 1);
    count_stall(n);
    chk(n == PER, "R7 idle length", n, PER);
    chk(tmr_irq == 1'b1, "R8 irq on idle exit", tmr_irq, 1);
    glb_irq_en = 1'b0;
    #1 chk(tmr_irq == 1'b0, "R8 irq masked by global enable", tmr_irq, 0);
    glb_irq_en = 1'b1;
    wr(2'd2, 8'h03);
    chk(tmr_irq == 1'b1, "R10 pending kept", tmr_irq, 1);
    wr(2'd2, 8'h01);
    chk(tmr_irq == 1'b0, "R10 pending cleared", tmr_irq, 0);
    wr(2'd1, 8'h00);

    // R8: idle with interrupt disabled
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h02);
    count_stall(n);
    chk(n == PER, "R7 idle length again", n, PER);
    chk(tmr_irq == 1'b0, "R8 no irq when disabled", tmr_irq, 0);
    wr(2'd1, 8'h00);

    // R7/R10: free-running timer in normal mode
    wr(2'd2, 8'h00);
    nxt(PER * 2 + 3);
    bus_addr = 2'd2; #1
    chk(bus_rdata[1] == 1'b1, "R7 pending in normal", bus_rdata, 2);
    nxt(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule